// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block is the programmable feedback divider of an integer-N frequency synthesizer. It works together with an external dual-modulus prescaler that divides the oscillator by either P or P+1. The block counts the prescaler's output pulses with two down-counters: a main counter loaded with B and a swallow counter loaded with A. It tells the prescaler which ratio to use through a modulus-control output. The prescaler runs at P+1 for the first A of its periods and at P for the remaining B-A. The whole chain therefore divides the oscillator by N = P*B + A, and the block emits one single-cycle pulse toward the phase detector for every N oscillator cycles.

The A and B values come from a configuration latch that may be rewritten at any time. The counters only pick up new values at a reload, so an output period is never corrupted part-way through. A setting with B = 0 or A > B cannot be divided this way. Such a setting parks the block with both outputs low until a usable setting is loaded. A synchronous counter-clear input restarts the count from the present setting.

Top module: `swallow_fb_divider`

## Requirements
- R1: While reset is active, and after reset until the first reload, `div_out` and `mod_sel` are both low.
- R2: With a legal setting, consecutive `div_out` pulses are exactly P*B + A clock cycles apart when `pre_tick` comes from a divide-by-P/P+1 prescaler that follows `mod_sel`. Equivalently, one pulse is produced for every B prescaler pulses.
- R3: After each reload with a legal setting, `mod_sel` is high (1 = divide by P+1) when A is nonzero and low when A is zero. It falls in the cycle after the prescaler pulse that brings the swallow count to zero, so exactly A prescaler periods per output period use P+1. `mod_sel` changes only after a `pre_tick` or `cnt_clr` cycle, and the swallow count never exceeds the main count while counting.
- R4: `div_out` is high for exactly one clock cycle. It is high in the cycle right after the `pre_tick` cycle that completes B prescaler pulses.
- R5: Changes to `swallow_val`/`main_val` have no effect on `mod_sel`, `div_out` or the period in progress. They take effect only at the next reload.
- R6: A setting with B = 0 or A > B is illegal. Once such a setting is loaded, `div_out` and `mod_sel` stay low. The block reloads at every `pre_tick`, so a legal setting loaded at a prescaler pulse gives its first `div_out` exactly N cycles after that pulse's clock edge.
- R7: `cnt_clr`, sampled high at a clock edge, reloads both counters from the present setting. It takes priority over a coincident `pre_tick`, so no `div_out` follows in the next cycle. If the prescaler restarts at the same edge, the next `div_out` comes N cycles after that edge.
- R8: The counter widths are parameters (`A_W`, `B_W`). Full-scale settings A = 2^A_W - 1 and B = 2^B_W - 1 divide correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; one cycle per oscillator input cycle in the prescaler model |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_clr | input | 1 | Synchronous counter clear: reload both counters from the setting |
| pre_tick | input | 1 | One-cycle strobe per prescaler output period |
| swallow_val | input | A_W | Swallow count A from the configuration latch |
| main_val | input | B_W | Main count B from the configuration latch |
| mod_sel | output | 1 | Prescaler modulus select: 1 = divide by P+1, 0 = divide by P |
| div_out | output | 1 | Divided output pulse, one cycle wide, once per N input cycles |

## Verification
The bench builds the divider with `A_W` = 4 and `B_W` = 6 and models the prescaler with P = 8 and P = 16. This keeps full-scale settings (A = 15, B = 63, N up to 1023) short enough to run. It also lets the bench visit every legal A for B from 1 to 20 at P = 8, and for B from 1 to 8 at P = 16. Each setting is written in the middle of the previous period, so every measured interval also checks that the change waited for the reload. Illegal settings, recovery from them, and a counter clear that lands on the terminal prescaler pulse are driven at chosen cycles.

// File: rtl/swallow_fb_pkg.sv
package swallow_fb_pkg;

  // Sequencer state of the feedback divider
  typedef enum logic [1:0] {
    SFD_IDLE = 2'd0,  // nothing loaded since reset
    SFD_RUN  = 2'd1,  // legal setting loaded, counting
    SFD_HOLD = 2'd2   // illegal setting loaded, outputs parked low
  } sfd_state_e;

  // A setting is usable when the main count is nonzero and covers the swallow count
  function automatic logic sfd_setting_ok(input int unsigned swallow,
                                          input int unsigned main_cnt);
    return (main_cnt != 0) && (swallow <= main_cnt);
  endfunction

endpackage

// File: rtl/sfd_rst_sync.sv
module sfd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] shift_q;

  generate
    if (STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= {shift_q[LAST-1:0], 1'b1};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= 1'b1;
      end
    end
  endgenerate

  assign rst_sync_n = shift_q[LAST];

endmodule

// File: rtl/sfd_main.sv
// Main down-counter: counts B prescaler pulses per output period.
module sfd_main #(
  parameter int B_W = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           dec,
  input  logic [B_W-1:0] load_val,
  output logic [B_W-1:0] cnt,
  output logic           last
);

  localparam logic [B_W-1:0] ONE = B_W'(1);

  logic [B_W-1:0] cnt_q, cnt_d;
  logic           cnt_en;

  always_comb begin
    cnt_en = load | dec;
    cnt_d  = cnt_q;
    if (load)     cnt_d = load_val;
    else if (dec) cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt  = cnt_q;
  assign last = (cnt_q == ONE);

endmodule

// File: rtl/sfd_swallow.sv
// Swallow down-counter and the registered modulus-control output.
module sfd_swallow #(
  parameter int A_W = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           load_ok,
  input  logic           step,
  input  logic [A_W-1:0] load_val,
  output logic [A_W-1:0] cnt,
  output logic           mod_sel
);

  localparam logic [A_W-1:0] ONE = A_W'(1);

  logic [A_W-1:0] cnt_q, cnt_d;
  logic           mod_q, mod_d;
  logic           live;
  logic           upd_en;

  always_comb begin
    live   = step && (cnt_q != '0);
    upd_en = load | live;
    cnt_d  = cnt_q;
    mod_d  = mod_q;
    if (load) begin
      cnt_d = load_val;
      mod_d = load_ok && (load_val != '0);
    end else if (live) begin
      cnt_d = cnt_q - ONE;
      mod_d = (cnt_q != ONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mod_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      mod_q <= mod_d;
    end
  end

  assign cnt     = cnt_q;
  assign mod_sel = mod_q;

endmodule

// File: rtl/sfd_seq.sv
// Reload sequencer: decides reload, count step and output pulse.
module sfd_seq
  import swallow_fb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cnt_clr,
  input  logic pre_tick,
  input  logic cfg_legal,
  input  logic main_last,
  output logic reload,
  output logic step,
  output logic div_out,
  output logic run,
  output logic hold
);

  sfd_state_e state_q, state_d;
  logic       fire_d;
  logic       div_q;

  always_comb begin
    reload  = 1'b0;
    step    = 1'b0;
    fire_d  = 1'b0;
    if (cnt_clr) begin
      reload = 1'b1;
    end else if (pre_tick) begin
      case (state_q)
        SFD_RUN: begin
          if (main_last) begin
            reload = 1'b1;
            fire_d = 1'b1;
          end else begin
            step = 1'b1;
          end
        end
        default: reload = 1'b1;
      endcase
    end
    state_d = state_q;
    if (reload) state_d = cfg_legal ? SFD_RUN : SFD_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state_q <= SFD_IDLE;
    else if (reload) state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= 1'b0;
    else        div_q <= fire_d;
  end

  assign div_out = div_q;
  assign run     = (state_q == SFD_RUN);
  assign hold    = (state_q == SFD_HOLD);

endmodule

// File: rtl/swallow_fb_divider.sv
module swallow_fb_divider
  import swallow_fb_pkg::*;
#(
  parameter int A_W         = 7,
  parameter int B_W         = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cnt_clr,
  input  logic           pre_tick,
  input  logic [A_W-1:0] swallow_val,
  input  logic [B_W-1:0] main_val,
  output logic           mod_sel,
  output logic           div_out
);

  logic           rst_sync_n;
  logic           cfg_legal;
  logic           reload;
  logic           step;
  logic           main_last;
  logic           run_w;
  logic           hold_w;
  logic [A_W-1:0] a_cnt_w;
  logic [B_W-1:0] b_cnt_w;

  sfd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign cfg_legal = sfd_setting_ok(32'(swallow_val), 32'(main_val));

  sfd_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cnt_clr   (cnt_clr),
    .pre_tick  (pre_tick),
    .cfg_legal (cfg_legal),
    .main_last (main_last),
    .reload    (reload),
    .step      (step),
    .div_out   (div_out),
    .run       (run_w),
    .hold      (hold_w)
  );

  sfd_swallow #(.A_W(A_W)) u_swallow (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (reload),
    .load_ok  (cfg_legal),
    .step     (step),
    .load_val (swallow_val),
    .cnt      (a_cnt_w),
    .mod_sel  (mod_sel)
  );

  sfd_main #(.B_W(B_W)) u_main (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (reload),
    .dec      (step),
    .load_val (main_val),
    .cnt      (b_cnt_w),
    .last     (main_last)
  );

endmodule

// File: rtl/swallow_fb_divider_chk.sv
module swallow_fb_divider_chk #(
  parameter int A_W = 7,
  parameter int B_W = 11
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cnt_clr,
  input logic           pre_tick,
  input logic           mod_sel,
  input logic           div_out,
  input logic           run,
  input logic           hold,
  input logic [A_W-1:0] a_cnt,
  input logic [B_W-1:0] b_cnt
);

  assert_pulse_origin_R4: assert property (@(posedge clk) disable iff (!rst_n)
    div_out |-> $past(pre_tick));

  assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    div_out |=> !div_out);

  assert_clear_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> !div_out);

  assert_hold_mod_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !mod_sel);

  assert_hold_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !div_out);

  assert_idle_mod_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !hold) |-> !mod_sel);

  assert_mod_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pre_tick && !cnt_clr) |=> $stable(mod_sel));

  assert_swallow_within_main_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (32'(a_cnt) <= 32'(b_cnt)));

endmodule

bind swallow_fb_divider swallow_fb_divider_chk #(.A_W(A_W), .B_W(B_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .cnt_clr  (cnt_clr),
  .pre_tick (pre_tick),
  .mod_sel  (mod_sel),
  .div_out  (div_out),
  .run      (run_w),
  .hold     (hold_w),
  .a_cnt    (a_cnt_w),
  .b_cnt    (b_cnt_w)
);

// File: tb/swallow_fb_divider_tb_top.sv
`timescale 1ns/1ps
module swallow_fb_divider_tb_top;

  localparam int A_W  = 4;
  localparam int B_W  = 6;
  localparam int A_MX = (1 << A_W) - 1;
  localparam int B_MX = (1 << B_W) - 1;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cnt_clr = 1'b0;
  logic [A_W-1:0] sw = '0;
  logic [B_W-1:0] mn = '0;
  logic           pre_tick;
  logic           mod_sel;
  logic           div_out;

  always #2.5 clk = ~clk;

  swallow_fb_divider #(.A_W(A_W), .B_W(B_W)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_clr     (cnt_clr),
    .pre_tick    (pre_tick),
    .swallow_val (sw),
    .main_val    (mn),
    .mod_sel     (mod_sel),
    .div_out     (div_out)
  );

  // Prescaler model: period of P or P+1 clocks, ratio taken from mod_sel
  // one cycle into each period; pulse in the last cycle of the period.
  int p_cur = 8;
  int pk;
  int plen;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pk   <= 0;
      plen <= p_cur;
    end else if (cnt_clr) begin
      pk   <= 0;
      plen <= p_cur;
    end else begin
      pk <= (pk == plen - 1) ? 0 : pk + 1;
      if (pk == 1) plen <= mod_sel ? p_cur + 1 : p_cur;
    end
  end
  assign pre_tick = rst_n && (pk == plen - 1);

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Output monitor
  int div_seen = 0, div_iv = 0, last_div = 0;
  int hi_cnt = 0, hi_last = 0;
  int tick_seen = 0, last_tick = 0;
  always @(negedge clk) begin
    if (div_out) begin
      div_seen = div_seen + 1;
      div_iv   = cyc - last_div;
      last_div = cyc;
      hi_last  = hi_cnt;
      hi_cnt   = 0;
    end
    if (pre_tick) begin
      tick_seen = tick_seen + 1;
      last_tick = cyc;
      if (plen == p_cur + 1) hi_cnt = hi_cnt + 1;
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic set_cfg(input int a, input int b);
    sw = A_W'(a);
    mn = B_W'(b);
  endtask

  task automatic wait_div(output int iv, output int hi);
    int n0 = div_seen;
    int g  = 0;
    while (div_seen == n0 && g < 3000) begin
      step();
      g++;
    end
    if (div_seen == n0) begin
      chk_eq("R2 div_out timeout", 0, 1);
      iv = -1;
      hi = -1;
    end else begin
      iv = div_iv;
      hi = hi_last;
    end
  endtask

  // Clear with a given setting and time the first output pulse
  task automatic clear_and_time(input int a, input int b);
    int n, c0, iv, hi;
    n = p_cur * b + a;
    set_cfg(a, b);
    cnt_clr = 1'b1;
    step();
    cnt_clr = 1'b0;
    c0 = cyc;
    chk_eq("R3 mod_sel after reload", int'(mod_sel), (a != 0) ? 1 : 0);
    wait_div(iv, hi);
    chk_eq("R7 first pulse after clear", last_div - c0, n);
  endtask

  // Every legal A for B = 1..bmax, each written mid-period
  task automatic run_sweep(input int p, input int bmax);
    int prev_n, prev_a, iv, hi, amax;
    p_cur = p;
    clear_and_time(0, 1);
    prev_n = p;
    prev_a = 0;
    for (int b = 1; b <= bmax; b++) begin
      amax = (b < A_MX) ? b : A_MX;
      for (int a = 0; a <= amax; a++) begin
        step();
        step();
        set_cfg(a, b);
        wait_div(iv, hi);
        chk_eq("R2/R5 period of previous setting", iv, prev_n);
        chk_eq("R3 P+1 periods per output", hi, prev_a);
        prev_n = p * b + a;
        prev_a = a;
      end
    end
    wait_div(iv, hi);
    chk_eq("R2 period of final setting", iv, prev_n);
    chk_eq("R3 P+1 periods final setting", hi, prev_a);
  endtask

  initial begin : wdog
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired (all requirements) actual=%0d expected=%0d", cyc, 190000);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    int iv, hi, d0, bad_div, bad_mod, tk, c0;

    // R1: reset state and the idle span before any reload
    repeat (4) step();
    chk_eq("R1 div_out in reset", int'(div_out), 0);
    chk_eq("R1 mod_sel in reset", int'(mod_sel), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step();
      chk_eq("R1 div_out before reload", int'(div_out), 0);
      chk_eq("R1 mod_sel before reload", int'(mod_sel), 0);
    end

    // R2, R3, R5: sweeps at two prescaler ratios
    run_sweep(8, 20);
    run_sweep(16, 8);

    // R8: full-scale settings
    p_cur = 8;
    clear_and_time(A_MX, B_MX);
    wait_div(iv, hi);
    chk_eq("R8 full-scale period P=8", iv, 8 * B_MX + A_MX);
    chk_eq("R8 full-scale P+1 periods", hi, A_MX);
    p_cur = 16;
    clear_and_time(A_MX, B_MX);
    wait_div(iv, hi);
    chk_eq("R8 full-scale period P=16", iv, 16 * B_MX + A_MX);
    clear_and_time(0, B_MX);
    wait_div(iv, hi);
    chk_eq("R3 zero swallow gives no P+1 periods", hi, 0);
    chk_eq("R8 max main count, zero swallow", iv, 16 * B_MX);

    // R5: raising A mid-period leaves mod_sel low until the reload
    p_cur = 8;
    clear_and_time(0, 4);
    step();
    step();
    set_cfg(3, 4);
    step();
    chk_eq("R5 mod_sel unchanged mid-period", int'(mod_sel), 0);
    wait_div(iv, hi);
    chk_eq("R5 old period kept", iv, 32);
    wait_div(iv, hi);
    chk_eq("R5 new period after reload", iv, 35);
    chk_eq("R5 new swallow after reload", hi, 3);

    // R6: illegal settings park the outputs
    clear_and_time(1, 3);
    step();
    step();
    set_cfg(5, 3);
    wait_div(iv, hi);
    chk_eq("R6 period before illegal load", iv, 25);
    d0 = div_seen;
    bad_div = 0;
    bad_mod = 0;
    for (int i = 0; i < 200; i++) begin
      step();
      if (mod_sel) bad_mod++;
      if (i == 100) set_cfg(0, 0);
    end
    bad_div = div_seen - d0;
    chk_eq("R6 no pulses while illegal", bad_div, 0);
    chk_eq("R6 mod_sel low while illegal", bad_mod, 0);

    // R6: recovery at the next prescaler pulse
    while (pre_tick) step();
    set_cfg(1, 2);
    d0 = tick_seen;
    while (tick_seen == d0) step();
    tk = last_tick;
    wait_div(iv, hi);
    chk_eq("R6 first pulse after legal load", last_div - tk, 17 + 1);
    wait_div(iv, hi);
    chk_eq("R6 steady period after recovery", iv, 17);

    // R7: clear on the terminal prescaler pulse suppresses the output
    while ((cyc - last_div) != 17 - 1) step();
    chk_eq("R7 terminal pulse present", int'(pre_tick), 1);
    cnt_clr = 1'b1;
    step();
    cnt_clr = 1'b0;
    c0 = cyc;
    chk_eq("R7 no pulse after clear on terminal tick", int'(div_out), 0);
    wait_div(iv, hi);
    chk_eq("R7 period restarts at clear", last_div - c0, 17);
    chk_eq("R4 pulse width one cycle", int'(div_out), 1);
    step();
    chk_eq("R4 pulse low next cycle", int'(div_out), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule